// File: doc/BRIEF.md
# Arithmetic Command, Status and Completion Controller

This block sits between a host bus and an arithmetic execution unit. The host writes an 8-bit command byte. The block splits the byte into an operation code, a number-format selector, a precision selector and a service-request flag. It starts the execution unit with a one-cycle start pulse and holds a busy state until the unit reports completion. On completion it captures the unit's result flags into an 8-bit status byte, which the host reads at any time.

Two completion signals tell the host that a command has finished. The end output is an interrupt that rises on every completion. It is cleared by an active-low acknowledge or by any host access to the core. The service request rises only for commands that asked for it. It falls on its own active-low acknowledge, or when a later command that did not ask for service completes. The arithmetic itself lies outside this block.

Control pins are plain strobes with no back-pressure. A command write is taken only while the block is idle and the format is legal. Any other command write is dropped and recorded in a sticky protocol-error flag.

Top module: `cmdstat_ctrl`

## Requirements
- R1: On an accepted command write, the block captures the byte's fields and drives them on `exe_op`, `exe_fixed` and `exe_single` from the next cycle until the next accepted write. Bits 4:0 drive `exe_op`, bit 5 drives `exe_fixed` (1 = fixed point) and bit 6 drives `exe_single` (1 = 16-bit).
- R2: A write taken while idle sets busy (`status[7]`) in the next cycle and raises `exe_start` for exactly one cycle.
- R3: When `exe_done` is high while busy, busy clears in the next cycle. The status byte then reads {0, sign, zero, error[3:0], carry} with sign in bit 6, zero in bit 5, the error code in bits 4:1 (for example 1000 = divide by zero) and carry in bit 0. It holds that value until the next completion.
- R4: While busy, `status` reads 8'h80: bits 6:0 are driven to zero.
- R5: `end_out` rises in the cycle after a completion and stays high until a cycle with `end_ack_n` low, `stat_rd`, `cmd_wr` or `data_acc` high. A completion in the same cycle as a clear still sets it.
- R6: With `end_ack_n` held low, `end_out` is high for exactly one clock per completion.
- R7: At completion, `svc_req` takes bit 7 of the completing command. It otherwise holds until `svc_ack_n` is low. A request from an earlier command stays high while a later command with bit 7 clear runs.
- R8: A command write while busy is ignored: there is no start pulse and the fields do not change. It sets `proto_err`, which stays high until reset.
- R9: A command byte with bit 6 high and bit 5 low is an illegal format. It is not started, busy stays low, and it sets `proto_err`.
- R10: Reset (`rst_n` low) clears busy, status, `exe_start`, `end_out`, `svc_req` and `proto_err` at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_byte | input | 8 | Command byte |
| stat_rd | input | 1 | Status read strobe (clears end) |
| data_acc | input | 1 | Operand port access strobe (clears end) |
| status | output | 8 | Status byte |
| exe_start | output | 1 | One-cycle start to execution unit |
| exe_op | output | 5 | Operation code |
| exe_fixed | output | 1 | Fixed point selected |
| exe_single | output | 1 | 16-bit precision selected |
| exe_done | input | 1 | Completion from execution unit |
| exe_sign | input | 1 | Result sign flag |
| exe_zero | input | 1 | Result zero flag |
| exe_carry | input | 1 | Result carry/borrow flag |
| exe_err | input | 4 | Result error code |
| end_out | output | 1 | End-of-execution interrupt |
| end_ack_n | input | 1 | Active-low end acknowledge |
| svc_req | output | 1 | Service request |
| svc_ack_n | input | 1 | Active-low service acknowledge |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The assertions assume that the execution unit raises `exe_done` for one cycle at a time and only while the block is busy. They also assume that every host strobe lasts one cycle. The bench plays the execution unit itself. It raises `exe_done` only after it has seen `exe_start`, and it drops each strobe after a single clock. Dropped writes are made only through deliberate writes while busy and deliberate illegal formats, and the bench applies reset after each of those scenarios.

// File: rtl/cmdstat_pkg.sv
package cmdstat_pkg;
  localparam int CMD_W  = 8;
  localparam int OP_W   = 5;
  localparam int ERR_W  = 4;
  localparam int STAT_W = 8;

  typedef struct packed {
    logic            svc;
    logic            single;
    logic            fixed;
    logic [OP_W-1:0] op;
  } cmd_t;

  typedef struct packed {
    logic             sign;
    logic             zero;
    logic [ERR_W-1:0] err;
    logic             carry;
  } res_t;
endpackage

// File: rtl/cs_cmd_decode.sv
module cs_cmd_decode
  import cmdstat_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_byte,
  output cmd_t             fields,
  output logic             legal
);
  always_comb begin
    fields = cmd_t'(cmd_byte);
    // 16-bit precision is only meaningful for fixed point
    legal  = !(fields.single && !fields.fixed);
  end
endmodule

// File: rtl/cs_busy_track.sv
module cs_busy_track
  import cmdstat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  cmd_t cmd_in,
  input  logic legal,
  input  logic exe_done,
  input  res_t res_in,
  output logic busy,
  output logic exe_start,
  output cmd_t cur_cmd,
  output res_t res_q,
  output logic proto_err,
  output logic done_evt,
  output logic done_svc
);
  logic accept;
  assign accept   = cmd_wr && !busy && legal;
  assign done_evt = busy && exe_done;
  assign done_svc = cur_cmd.svc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      exe_start <= 1'b0;
      cur_cmd   <= '0;
      res_q     <= '0;
      proto_err <= 1'b0;
    end else begin
      exe_start <= accept;
      if (accept) begin
        busy    <= 1'b1;
        cur_cmd <= cmd_in;
      end else if (done_evt) begin
        busy  <= 1'b0;
        res_q <= res_in;
      end
      if (cmd_wr && (busy || !legal)) proto_err <= 1'b1;
    end
  end

  // R2: start is a single-cycle pulse and coincides with busy
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exe_start |=> !exe_start);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    exe_start |-> busy);
  // R3: completion ends busy
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && exe_done) |=> !busy);
  // R8: write while busy leaves the captured command alone and flags it
  a_r8_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> ($stable(cur_cmd) && proto_err && !exe_start));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  // R9: illegal format never starts
  a_r9_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !legal) |=> (!busy && !exe_start));
endmodule

// File: rtl/cs_completion.sv
module cs_completion (
  input  logic clk,
  input  logic rst_n,
  input  logic done_evt,
  input  logic done_svc,
  input  logic end_ack_n,
  input  logic svc_ack_n,
  input  logic access,
  output logic end_out,
  output logic svc_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_out <= 1'b0;
      svc_req <= 1'b0;
    end else begin
      if (done_evt)                    end_out <= 1'b1;
      else if (!end_ack_n || access)   end_out <= 1'b0;

      if (done_evt)                    svc_req <= done_svc;
      else if (!svc_ack_n)             svc_req <= 1'b0;
    end
  end

  // R5: every completion raises the end interrupt
  a_r5_end_set: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> end_out);
  // R6: acknowledge held low makes the end output one clock wide
  a_r6_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (end_out && !end_ack_n && !done_evt) |=> !end_out);
  // R7: completion of a no-service command drops the request
  a_r7_svc_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !done_svc) |=> !svc_req);
  a_r7_svc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && svc_ack_n && !done_evt) |=> svc_req);
endmodule

// File: rtl/cmdstat_ctrl.sv
module cmdstat_ctrl
  import cmdstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_byte,
  input  logic              stat_rd,
  input  logic              data_acc,
  output logic [STAT_W-1:0] status,
  output logic              exe_start,
  output logic [OP_W-1:0]   exe_op,
  output logic              exe_fixed,
  output logic              exe_single,
  input  logic              exe_done,
  input  logic              exe_sign,
  input  logic              exe_zero,
  input  logic              exe_carry,
  input  logic [ERR_W-1:0]  exe_err,
  output logic              end_out,
  input  logic              end_ack_n,
  output logic              svc_req,
  input  logic              svc_ack_n,
  output logic              proto_err
);
  cmd_t dec_fields, cur_cmd;
  res_t res_in, res_q;
  logic legal, busy, done_evt, done_svc;

  assign res_in = '{sign: exe_sign, zero: exe_zero, err: exe_err, carry: exe_carry};

  cs_cmd_decode u_dec (
    .cmd_byte (cmd_byte),
    .fields   (dec_fields),
    .legal    (legal)
  );

  cs_busy_track u_busy (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_in    (dec_fields),
    .legal     (legal),
    .exe_done  (exe_done),
    .res_in    (res_in),
    .busy      (busy),
    .exe_start (exe_start),
    .cur_cmd   (cur_cmd),
    .res_q     (res_q),
    .proto_err (proto_err),
    .done_evt  (done_evt),
    .done_svc  (done_svc)
  );

  cs_completion u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_evt  (done_evt),
    .done_svc  (done_svc),
    .end_ack_n (end_ack_n),
    .svc_ack_n (svc_ack_n),
    .access    (cmd_wr || stat_rd || data_acc),
    .end_out   (end_out),
    .svc_req   (svc_req)
  );

  assign exe_op     = cur_cmd.op;
  assign exe_fixed  = cur_cmd.fixed;
  assign exe_single = cur_cmd.single;
  // result flags are undefined while busy; drive them as zero
  assign status     = busy ? {1'b1, {(STAT_W-1){1'b0}}} : {1'b0, res_q};

  // R4: busy status shows only the busy bit
  a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
    exe_start |-> (status == 8'h80));
  // R3: a completion leaves the captured flags visible
  a_r3_status_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && exe_done) |=> (status == {1'b0, $past(res_in)}));
endmodule

// File: tb/tb_cmdstat_ctrl.sv
module tb_cmdstat_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0, stat_rd = 1'b0, data_acc = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] status;
  logic       exe_start, exe_fixed, exe_single;
  logic [4:0] exe_op;
  logic       exe_done = 1'b0, exe_sign = 1'b0, exe_zero = 1'b0, exe_carry = 1'b0;
  logic [3:0] exe_err = 4'h0;
  logic       end_out, svc_req, proto_err;
  logic       end_ack_n = 1'b1, svc_ack_n = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  always #2 clk = ~clk;

  cmdstat_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .stat_rd(stat_rd), .data_acc(data_acc), .status(status),
    .exe_start(exe_start), .exe_op(exe_op), .exe_fixed(exe_fixed),
    .exe_single(exe_single), .exe_done(exe_done), .exe_sign(exe_sign),
    .exe_zero(exe_zero), .exe_carry(exe_carry), .exe_err(exe_err),
    .end_out(end_out), .end_ack_n(end_ack_n), .svc_req(svc_req),
    .svc_ack_n(svc_ack_n), .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic issue(input logic [7:0] c);
    cmd_wr = 1'b1; cmd_byte = c; tick(); cmd_wr = 1'b0;
  endtask

  task automatic finish(input logic s, input logic z, input logic [3:0] e, input logic cy);
    exe_done = 1'b1; exe_sign = s; exe_zero = z; exe_err = e; exe_carry = cy;
    tick(); exe_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; #1; rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
  endtask

  task automatic t_reset_state();
    chk("R10 status", status, 8'h00);
    chk("R10 end", end_out, 1'b0);
    chk("R10 svc", svc_req, 1'b0);
    chk("R10 proto", proto_err, 1'b0);
    chk("R10 start", exe_start, 1'b0);
  endtask

  task automatic t_fixed_cmd();
    issue(8'h6C);
    chk("R2 start", exe_start, 1'b1);
    chk("R1 op", exe_op, 5'h0C);
    chk("R1 fixed", exe_fixed, 1'b1);
    chk("R1 single", exe_single, 1'b1);
    tick();
    chk("R2 start one cycle", exe_start, 1'b0);
    chk("R4 busy status", status, 8'h80);
    finish(1'b1, 1'b0, 4'b1000, 1'b1);
    chk("R3 status", status, 8'h51);
    chk("R5 end set", end_out, 1'b1);
    chk("R7 svc no request", svc_req, 1'b0);
    tick();
    chk("R5 end holds", end_out, 1'b1);
    end_ack_n = 1'b0; tick(); end_ack_n = 1'b1;
    chk("R5 end ack clear", end_out, 1'b0);
    chk("R3 status held", status, 8'h51);
  endtask

  task automatic t_service();
    issue(8'h92);
    chk("R1 float op", exe_op, 5'h12);
    chk("R1 float fixed", exe_fixed, 1'b0);
    chk("R1 float single", exe_single, 1'b0);
    finish(1'b0, 1'b1, 4'b0000, 1'b0);
    chk("R3 zero status", status, 8'h20);
    chk("R7 svc set", svc_req, 1'b1);
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    chk("R5 read clears end", end_out, 1'b0);
    tick(); tick();
    chk("R7 svc holds", svc_req, 1'b1);
    issue(8'h10);
    tick();
    chk("R7 svc kept while no-request cmd runs", svc_req, 1'b1);
    finish(1'b0, 1'b0, 4'b0100, 1'b0);
    chk("R7 svc dropped", svc_req, 1'b0);
    chk("R3 err status", status, 8'h08);
    data_acc = 1'b1; tick(); data_acc = 1'b0;
    chk("R5 data access clears end", end_out, 1'b0);
    issue(8'h81);
    finish(1'b0, 1'b0, 4'b0000, 1'b0);
    chk("R7 svc set again", svc_req, 1'b1);
    svc_ack_n = 1'b0; tick(); svc_ack_n = 1'b1;
    chk("R7 svc ack clear", svc_req, 1'b0);
    chk("R5 end before write", end_out, 1'b1);
    issue(8'h00);
    chk("R5 write clears end", end_out, 1'b0);
    finish(1'b0, 1'b0, 4'b0000, 1'b0);
    end_ack_n = 1'b0; tick(); end_ack_n = 1'b1;
  endtask

  task automatic t_pulse();
    end_ack_n = 1'b0;
    issue(8'h2C);
    finish(1'b0, 1'b0, 4'b0000, 1'b1);
    chk("R6 end rises with ack low", end_out, 1'b1);
    tick();
    chk("R6 end one clock", end_out, 1'b0);
    end_ack_n = 1'b1;
  endtask

  task automatic t_busy_write();
    issue(8'h6D);
    chk("R8 proto before", proto_err, 1'b0);
    tick();
    cmd_wr = 1'b1; cmd_byte = 8'h2E; tick(); cmd_wr = 1'b0;
    chk("R8 no start", exe_start, 1'b0);
    chk("R8 op kept", exe_op, 5'h0D);
    chk("R8 single kept", exe_single, 1'b1);
    chk("R8 proto set", proto_err, 1'b1);
    finish(1'b0, 1'b0, 4'b0000, 1'b0);
    tick();
    chk("R8 proto sticky", proto_err, 1'b1);
    do_reset();
  endtask

  task automatic t_illegal();
    issue(8'h4C);
    chk("R9 not busy", status[7], 1'b0);
    chk("R9 no start", exe_start, 1'b0);
    chk("R9 proto", proto_err, 1'b1);
    do_reset();
  endtask

  task automatic t_reset_mid();
    issue(8'h90);
    finish(1'b1, 1'b0, 4'b0010, 1'b0);
    chk("R10 pre svc", svc_req, 1'b1);
    chk("R10 pre status", status, 8'h44);
    rst_n = 1'b0; #1;
    chk("R10 end cleared", end_out, 1'b0);
    chk("R10 svc cleared", svc_req, 1'b0);
    chk("R10 status cleared", status, 8'h00);
    tick(); rst_n = 1'b1; tick();
    issue(8'h93);
    rst_n = 1'b0; #1;
    chk("R10 busy cleared", status[7], 1'b0);
    chk("R10 start cleared", exe_start, 1'b0);
    tick(); rst_n = 1'b1; tick();
  endtask

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset_state();
    t_fixed_cmd();
    t_service();
    t_pulse();
    t_busy_write();
    t_illegal();
    t_reset_mid();
    done_run = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule